// File: doc/BRIEF.md
# Always-On Time Base with Compare Interrupt

This block keeps a free-running 56-bit time base that advances by one on every clock and is meant to stay powered for the life of the system. Software reaches it through a simple 32-bit register port with a write strobe and a combinationally decoded read path. The count is seen as two 32-bit words: a low word and a high word. The upper eight bits of the high word are always zero. The high word moves only when the low word wraps, so software obtains a consistent 64-bit value by reading high, low and high again, and retrying if the two high reads differ.

A single compare frame sits at address 0x10000. It holds a 64-bit compare value, written as a high word and a low word (high first by convention), and a control word. The frame is run by a three-state machine. In `CMP_OFF` the frame is disabled. Setting the enable bit takes the transition `arm` to `CMP_ARMED`. While armed, the transition `hit` to `CMP_HIT` is taken when the zero-extended count is greater than or equal to the compare value. Clearing the enable bit takes the transition `disarm` from `CMP_ARMED` or `CMP_HIT` back to `CMP_OFF`. The status flag is simply "in `CMP_HIT`". The interrupt is a registered copy of status AND NOT mask. Clearing enable is the only way to acknowledge it.

Address map (byte offsets): 0x00008 count low, 0x0000C count high, 0x10020 compare low, 0x10024 compare high, 0x1002C control (bit 0 enable, bit 1 mask, bit 2 status, read-only).

Top module: `sctr_timebase`

## Requirements
- R1: While reset is asserted, the count reads the `CNT_INIT` parameter value, both compare words read zero, the control word reads zero and `irq` is low.
- R2: The count low word (0x00008) increases by exactly one per clock; bits 31:24 of the count high word (0x0000C) always read zero.
- R3: The count high word changes only on the clock where the low word goes from 0xFFFFFFFF to 0x00000000, and then it increases by one.
- R4: The 56-bit count rolls over from all ones to zero, with both words reading zero after the wrap.
- R5: The compare low word (0x10020) and high word (0x10024) read back the last values written to them.
- R6: With enable (control bit 0) set, the status bit (control bit 2) reads one from the clock after the count first equals or exceeds the compare value, so the first low word seen with status set is the compare low word plus one. The count is zero-extended to 64 bits, so a compare value with any of bits 63:56 set never fires.
- R7: `irq` equals status AND NOT mask (control bit 1) in every cycle, and follows a mask change on the clock of the control write.
- R8: Writing the control word with bit 0 clear drops status and `irq` on that clock.
- R9: Control bit 2 cannot be written. Writes to the count words are ignored and do not disturb the count.
- R10: Reads of any address outside the five mapped words return zero.
- R11: While the frame is disabled, status stays zero even if the count is past the compare value. Enabling in that situation reads status zero one clock after the write and one the clock after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_addr | input | ADDR_W | Byte address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Registered compare interrupt, active high |

## Verification
The hardest behaviour to reach from the ports is the carry from the low word into the high word, together with the 56-bit rollover: a reset count of zero needs 2^32 clocks before the first carry. The bench therefore sets `CNT_INIT` to 256 below the full 56-bit range. A single carry then arrives a few hundred clocks after reset, and the bench watches it word by word. The compare-fire cycle is pinned by programming a value a fixed distance ahead of a freshly read count and requiring that the first low word seen with status set is exactly one past it.

// File: rtl/sctr_pkg.sv
package sctr_pkg;

    // Compare frame state
    typedef enum logic [1:0] {
        CMP_OFF   = 2'd0,
        CMP_ARMED = 2'd1,
        CMP_HIT   = 2'd2
    } cmp_state_e;

    // Register offsets
    localparam int CNT_LO_OFS   = 32'h0000_0008;
    localparam int CNT_HI_OFS   = 32'h0000_000C;
    localparam int CMP_BASE     = 32'h0001_0000;
    localparam int CMP_LO_OFS   = CMP_BASE + 32'h20;
    localparam int CMP_HI_OFS   = CMP_BASE + 32'h24;
    localparam int CMP_CTRL_OFS = CMP_BASE + 32'h2C;

    // Control word bit positions
    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_MASK_BIT = 1;
    localparam int CTRL_STAT_BIT = 2;

endpackage

// File: rtl/sctr_counter.sv
module sctr_counter #(
    parameter int              CNT_W = 56,
    parameter logic [CNT_W-1:0] INIT = '0
) (
    input  logic               clk,
    input  logic               rst,
    output logic [31:0]        cnt_lo,
    output logic [CNT_W-33:0]  cnt_hi
);
    localparam int HI_W = CNT_W - 32;

    logic [31:0]     lo_q;
    logic [HI_W-1:0] hi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q <= INIT[31:0];
            hi_q <= INIT[CNT_W-1:32];
        end else begin
            lo_q <= lo_q + 32'd1;
            if (lo_q == '1)
                hi_q <= hi_q + {{(HI_W-1){1'b0}}, 1'b1};
        end
    end

    assign cnt_lo = lo_q;
    assign cnt_hi = hi_q;

    // R2
    lo_step_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> lo_q == $past(lo_q) + 32'd1);

    // R3
    hi_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (lo_q != '1) |=> $stable(hi_q));

    // R3
    hi_step_chk: assert property (@(posedge clk) disable iff (rst)
        (lo_q == '1) |=> hi_q == $past(hi_q) + {{(HI_W-1){1'b0}}, 1'b1});

endmodule

// File: rtl/sctr_cmp_fsm.sv
module sctr_cmp_fsm
    import sctr_pkg::*;
#(
    parameter int CNT_W = 56,
    parameter int CMP_W = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CMP_W-1:0] cmp,
    input  logic             ctrl_wr,
    input  logic             ctrl_en_w,
    input  logic             ctrl_mask_w,
    output logic             en,
    output logic             mask,
    output logic             status,
    output logic             irq
);
    localparam int PAD_W = CMP_W - CNT_W;

    cmp_state_e state_q, state_d;
    logic       mask_q, mask_d;
    logic       irq_q;
    logic       hit;
    logic       disarm;
    logic       arm;

    assign hit    = {{PAD_W{1'b0}}, cnt} >= cmp;
    assign arm    = ctrl_wr &&  ctrl_en_w;
    assign disarm = ctrl_wr && !ctrl_en_w;
    assign mask_d = ctrl_wr ? ctrl_mask_w : mask_q;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CMP_OFF:   if (arm)    state_d = CMP_ARMED;
            CMP_ARMED: if (disarm) state_d = CMP_OFF;
                       else if (hit) state_d = CMP_HIT;
            CMP_HIT:   if (disarm) state_d = CMP_OFF;
            default:   state_d = CMP_OFF;
        endcase
    end

    // State register and registered interrupt
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= CMP_OFF;
            mask_q  <= 1'b0;
            irq_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            mask_q  <= mask_d;
            irq_q   <= (state_d == CMP_HIT) && !mask_d;
        end
    end

    // Outputs
    always_comb begin
        en     = (state_q != CMP_OFF);
        status = (state_q == CMP_HIT);
        mask   = mask_q;
        irq    = irq_q;
    end

    // R6
    fire_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(status) |-> $past(hit) && $past(en));

    // R7
    irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> status && !mask);

    // R8
    disarm_clear_chk: assert property (@(posedge clk) disable iff (rst)
        disarm |=> !status && !irq && !en);

    // R11
    off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!en && !arm) |=> !status);

endmodule

// File: rtl/sctr_regs.sv
module sctr_regs
    import sctr_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int CNT_W  = 56
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic [31:0]       cnt_lo,
    input  logic [CNT_W-33:0] cnt_hi,
    input  logic              en,
    input  logic              mask,
    input  logic              status,
    output logic [63:0]       cmp,
    output logic              ctrl_wr,
    output logic              ctrl_en_w,
    output logic              ctrl_mask_w,
    output logic [31:0]       bus_rdata
);
    localparam int HI_W  = CNT_W - 32;
    localparam int PAD_W = 32 - HI_W;

    logic sel_cnt_lo, sel_cnt_hi, sel_cmp_lo, sel_cmp_hi, sel_ctrl;
    logic [31:0] cmp_lo_q, cmp_hi_q;

    assign sel_cnt_lo = bus_addr == ADDR_W'(CNT_LO_OFS);
    assign sel_cnt_hi = bus_addr == ADDR_W'(CNT_HI_OFS);
    assign sel_cmp_lo = bus_addr == ADDR_W'(CMP_LO_OFS);
    assign sel_cmp_hi = bus_addr == ADDR_W'(CMP_HI_OFS);
    assign sel_ctrl   = bus_addr == ADDR_W'(CMP_CTRL_OFS);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_lo_q <= '0;
            cmp_hi_q <= '0;
        end else if (bus_wr) begin
            if (sel_cmp_lo) cmp_lo_q <= bus_wdata;
            if (sel_cmp_hi) cmp_hi_q <= bus_wdata;
        end
    end

    assign cmp         = {cmp_hi_q, cmp_lo_q};
    assign ctrl_wr     = bus_wr && sel_ctrl;
    assign ctrl_en_w   = bus_wdata[CTRL_EN_BIT];
    assign ctrl_mask_w = bus_wdata[CTRL_MASK_BIT];

    always_comb begin
        bus_rdata = '0;
        if (sel_cnt_lo) bus_rdata = cnt_lo;
        if (sel_cnt_hi) bus_rdata = {{PAD_W{1'b0}}, cnt_hi};
        if (sel_cmp_lo) bus_rdata = cmp_lo_q;
        if (sel_cmp_hi) bus_rdata = cmp_hi_q;
        if (sel_ctrl) begin
            bus_rdata[CTRL_EN_BIT]   = en;
            bus_rdata[CTRL_MASK_BIT] = mask;
            bus_rdata[CTRL_STAT_BIT] = status;
        end
    end

    // R5
    cmp_lo_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && sel_cmp_lo) |=> cmp_lo_q == $past(bus_wdata));

    // R5
    cmp_hi_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && sel_cmp_hi) |=> cmp_hi_q == $past(bus_wdata));

    // R5
    cmp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && (sel_cmp_lo || sel_cmp_hi)) |=> $stable(cmp));

endmodule

// File: rtl/sctr_timebase.sv
module sctr_timebase
    import sctr_pkg::*;
#(
    parameter int              ADDR_W   = 20,
    parameter int              CNT_W    = 56,
    parameter logic [CNT_W-1:0] CNT_INIT = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq
);
    localparam int CMP_W = 64;
    localparam int HI_W  = CNT_W - 32;

    logic [31:0]      cnt_lo;
    logic [HI_W-1:0]  cnt_hi;
    logic [CMP_W-1:0] cmp;
    logic             ctrl_wr, ctrl_en_w, ctrl_mask_w;
    logic             en, mask, status;

    sctr_counter #(.CNT_W(CNT_W), .INIT(CNT_INIT)) u_counter (
        .clk    (clk),
        .rst    (rst),
        .cnt_lo (cnt_lo),
        .cnt_hi (cnt_hi)
    );

    sctr_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .cnt_lo      (cnt_lo),
        .cnt_hi      (cnt_hi),
        .en          (en),
        .mask        (mask),
        .status      (status),
        .cmp         (cmp),
        .ctrl_wr     (ctrl_wr),
        .ctrl_en_w   (ctrl_en_w),
        .ctrl_mask_w (ctrl_mask_w),
        .bus_rdata   (bus_rdata)
    );

    sctr_cmp_fsm #(.CNT_W(CNT_W), .CMP_W(CMP_W)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .cnt         ({cnt_hi, cnt_lo}),
        .cmp         (cmp),
        .ctrl_wr     (ctrl_wr),
        .ctrl_en_w   (ctrl_en_w),
        .ctrl_mask_w (ctrl_mask_w),
        .en          (en),
        .mask        (mask),
        .status      (status),
        .irq         (irq)
    );

    // R9
    stat_ro_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && !en) |=> !status);

endmodule

// File: tb/sctr_timebase_tb.sv
module sctr_timebase_tb;

    localparam int ADDR_W = 20;
    localparam logic [55:0] INIT = 56'hFF_FFFF_FFFF_FF00;

    localparam logic [19:0] A_CLO  = 20'h00008;
    localparam logic [19:0] A_CHI  = 20'h0000C;
    localparam logic [19:0] A_MLO  = 20'h10020;
    localparam logic [19:0] A_MHI  = 20'h10024;
    localparam logic [19:0] A_CTRL = 20'h1002C;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              irq;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    sctr_timebase #(.ADDR_W(ADDR_W), .CNT_W(56), .CNT_INIT(INIT)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // Called at a negedge; result valid without advancing time past the next posedge
    task automatic rd(input logic [19:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wr(input logic [19:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(A_CLO, v);  check(v == INIT[31:0], "R1 count low in reset", v, INIT[31:0]);
        rd(A_CHI, v);  check(v == {8'h0, INIT[55:32]}, "R1 count high in reset", v, {8'h0, INIT[55:32]});
        rd(A_MLO, v);  check(v == 0, "R1 compare low in reset", v, 0);
        rd(A_MHI, v);  check(v == 0, "R1 compare high in reset", v, 0);
        rd(A_CTRL, v); check(v == 0, "R1 control in reset", v, 0);
        check(irq == 1'b0, "R1 irq in reset", {31'h0, irq}, 0);
    endtask

    task automatic t_step;
        logic [31:0] a, b, h;
        rd(A_CLO, a);
        @(negedge clk);
        rd(A_CLO, b);
        check(b == a + 1, "R2 low word step", b, a + 1);
        rd(A_CHI, h);
        check(h[31:24] == 8'h0, "R2 high word upper bits", h, {8'h0, h[23:0]});
    endtask

    task automatic t_wrap;
        logic [31:0] plo, phi, lo, hi;
        bit seen = 0;
        rd(A_CLO, plo); rd(A_CHI, phi);
        for (int i = 0; i < 400 && !seen; i++) begin
            @(negedge clk);
            rd(A_CLO, lo); rd(A_CHI, hi);
            if (hi != phi) begin
                seen = 1;
                check(plo == 32'hFFFF_FFFF, "R3 high moves only at low wrap", plo, 32'hFFFF_FFFF);
                check(lo == 0, "R4 low word after rollover", lo, 0);
                check(hi == 0, "R4 high word after rollover", hi, 0);
            end
            plo = lo; phi = hi;
        end
        check(seen, "R3 carry observed", {31'h0, seen}, 1);
    endtask

    task automatic t_unmapped;
        logic [31:0] v;
        rd(20'h00004, v); check(v == 0, "R10 unmapped 0x00004", v, 0);
        rd(20'h10000, v); check(v == 0, "R10 unmapped 0x10000", v, 0);
        rd(20'h10028, v); check(v == 0, "R10 unmapped 0x10028", v, 0);
        rd(20'h20008, v); check(v == 0, "R10 unmapped 0x20008", v, 0);
    endtask

    task automatic t_cmp_rw;
        logic [31:0] v;
        wr(A_MHI, 32'hDEAD_BEEF);
        wr(A_MLO, 32'h1234_5678);
        rd(A_MHI, v); check(v == 32'hDEAD_BEEF, "R5 compare high readback", v, 32'hDEAD_BEEF);
        rd(A_MLO, v); check(v == 32'h1234_5678, "R5 compare low readback", v, 32'h1234_5678);
    endtask

    task automatic t_fire;
        logic [31:0] now, c, v, lo;
        bit got = 0;
        rd(A_CLO, now);
        c = now + 32'd20;
        wr(A_MHI, 32'h0);
        wr(A_MLO, c);
        wr(A_CTRL, 32'h1);
        for (int i = 0; i < 100 && !got; i++) begin
            rd(A_CTRL, v);
            if (v[2]) begin
                got = 1;
                rd(A_CLO, lo);
                check(lo == c + 1, "R6 status on first count at or past compare", lo, c + 1);
                check(irq == 1'b1, "R7 irq with status and no mask", {31'h0, irq}, 1);
            end else begin
                check(irq == 1'b0, "R7 irq low before status", {31'h0, irq}, 0);
                @(negedge clk);
            end
        end
        check(got, "R6 status reached", {31'h0, got}, 1);
    endtask

    task automatic t_clear;
        logic [31:0] v;
        wr(A_CTRL, 32'h0);
        rd(A_CTRL, v); check(v == 0, "R8 disable clears status", v, 0);
        check(irq == 1'b0, "R8 disable drops irq", {31'h0, irq}, 0);
    endtask

    task automatic t_late_enable;
        logic [31:0] v;
        repeat (10) @(negedge clk);
        rd(A_CTRL, v); check(v == 0, "R11 disabled frame past compare stays quiet", v, 0);
        wr(A_CTRL, 32'h1);
        rd(A_CTRL, v); check(v == 32'h1, "R11 armed one clock after enable", v, 32'h1);
        @(negedge clk);
        rd(A_CTRL, v); check(v == 32'h5, "R11 fires next clock", v, 32'h5);
        wr(A_CTRL, 32'h0);
    endtask

    task automatic t_mask;
        logic [31:0] v;
        wr(A_CTRL, 32'h3);
        @(negedge clk);
        rd(A_CTRL, v); check(v == 32'h7, "R7 masked frame fires", v, 32'h7);
        check(irq == 1'b0, "R7 mask holds irq low", {31'h0, irq}, 0);
        wr(A_CTRL, 32'h1);
        check(irq == 1'b1, "R7 unmask raises irq", {31'h0, irq}, 1);
        wr(A_CTRL, 32'h3);
        check(irq == 1'b0, "R7 remask drops irq", {31'h0, irq}, 0);
        wr(A_CTRL, 32'h0);
    endtask

    task automatic t_readonly;
        logic [31:0] v, a, b;
        wr(A_MHI, 32'h00FF_FFFF);
        wr(A_MLO, 32'hFFFF_FFFF);
        wr(A_CTRL, 32'h4);
        rd(A_CTRL, v); check(v == 0, "R9 status bit not writable", v, 0);
        rd(A_CLO, a);
        wr(A_CLO, 32'h0);
        rd(A_CLO, b); check(b == a + 1, "R9 count low write ignored", b, a + 1);
        wr(A_CHI, 32'h1234_5678);
        rd(A_CHI, v); check(v == 0, "R9 count high write ignored", v, 0);
    endtask

    task automatic t_zext;
        logic [31:0] v;
        wr(A_MHI, 32'h0100_0000);
        wr(A_MLO, 32'h0);
        wr(A_CTRL, 32'h1);
        repeat (30) @(negedge clk);
        rd(A_CTRL, v); check(v == 32'h1, "R6 compare above 56 bits never fires", v, 32'h1);
        check(irq == 1'b0, "R6 no irq for out-of-range compare", {31'h0, irq}, 0);
        wr(A_CTRL, 32'h0);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                failures++;
                checks++;
                $display("FAIL watchdog actual=%0d expected<=100000", cycles);
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_step();
        t_wrap();
        t_unmapped();
        t_cmp_rw();
        t_fire();
        t_clear();
        t_late_enable();
        t_mask();
        t_readonly();
        t_zext();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule